// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This block is a memory-mapped watchdog. A 32-bit down-counter is reloaded from a programmable load value. When the count runs out the first time, the block raises an interrupt as a warning and starts the count again from the load value. If software has not cleared that interrupt by the time the count runs out a second time, and the reset stage is enabled, the block asserts a system reset output. That output stays asserted until the block's own reset input is applied.

Software keeps the system alive by writing the interrupt-clear register. That write clears the pending interrupt and restarts the count. All register writes except those to the lock register can be blocked. Writing a single key value to the lock register opens write access, and writing any other value there closes it again. Reads are always allowed. The register bus is a plain synchronous interface with address, write enable, write data and read data that is combinational from the address.

Register offsets: load 0x000, current count 0x004 (read-only), control 0x008, interrupt clear 0x00C (write-only), raw status 0x010, masked status 0x014, lock 0xC00.

Top module: `twostage_wdog`

## Requirements
- R1: After reset the block is unlocked, the control register is 0, the load and count registers both read 0xFFFFFFFF, both status registers read 0, and `irqOut` and `sysRstOut` are low.
- R2: Writing 0x1ACCE551 to offset 0xC00 unlocks the block, and writing any other value there locks it. A read of 0xC00 returns 1 while locked and 0 while unlocked.
- R3: While the block is locked, writes to every offset other than 0xC00 have no effect. Reads still return current values.
- R4: A write to offset 0x000 stores the written value as the load value and reloads the counter with it in the same cycle. A written value of 0 is stored and loaded as 1.
- R5: Control bit 0 enables counting and the interrupt, and control bit 1 enables the reset stage. While bit 0 is set, the count at 0x004 drops by one each cycle. While bit 0 is clear, the count holds.
- R6: While counting is enabled, a count of 0 is followed on the next cycle by a reload from the load value and by setting bit 0 of the raw status register at 0x010. With load value L, an expiry therefore occurs every L+1 cycles.
- R7: An expiry that finds the raw interrupt already set while control bit 1 is set drives `sysRstOut` high. It stays high, whatever is written, until `rstN` is asserted.
- R8: Any unlocked write to offset 0x00C clears the raw interrupt and reloads the counter from the load value.
- R9: Bit 0 of the masked status at 0x014, and the `irqOut` pin, both equal the raw interrupt ANDed with control bit 0.
- R10: A read of any unmapped offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 12 | Register byte offset |
| busWe | input | 1 | Write enable for the current cycle |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from `busAddr` |
| irqOut | output | 1 | First-stage interrupt (masked) |
| sysRstOut | output | 1 | Second-stage system reset request, sticky |

## Verification
A wrong counter state shows up at offset 0x004 on the very next read, and any error in the expiry period moves the cycle in which the raw status bit rises. A stuck or early raw interrupt is visible at 0x010 and on `irqOut` in the cycle after the expiry it belongs to. A fault in the reset stage is seen one full period later, as `sysRstOut` coming up too soon, too late, or dropping early. A fault in the lock shows up as a readback of a register that changed even though it should have been protected.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [11:0] OFS_LOAD  = 12'h000;
  localparam logic [11:0] OFS_COUNT = 12'h004;
  localparam logic [11:0] OFS_CTRL  = 12'h008;
  localparam logic [11:0] OFS_CLR   = 12'h00C;
  localparam logic [11:0] OFS_RAW   = 12'h010;
  localparam logic [11:0] OFS_MASK  = 12'h014;
  localparam logic [11:0] OFS_LOCK  = 12'hC00;
  localparam logic [31:0] UNLOCK_KEY = 32'h1ACC_E551;

  typedef struct packed {
    logic reload;   // restart count from reloadVal
    logic clrIrq;   // drop pending interrupt
  } wdStrobe_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [DATA_W-1:0] cntVal,
  input  logic              irqRaw,
  output logic [DATA_W-1:0] reloadVal,
  output logic              runEn,
  output logic              rstEn,
  output logic              lockedQ,
  output logic [1:0]        ctrlQ,
  output wdStrobe_t         strobe
);
  localparam logic [DATA_W-1:0] LOAD_MIN = DATA_W'(1);

  logic [DATA_W-1:0] loadQ;
  logic [DATA_W-1:0] wdataClamped;
  logic              writeOk;
  logic              hitLoad, hitCtrl, hitClr, hitLock;

  assign hitLoad = (busAddr == ADDR_W'(OFS_LOAD));
  assign hitCtrl = (busAddr == ADDR_W'(OFS_CTRL));
  assign hitClr  = (busAddr == ADDR_W'(OFS_CLR));
  assign hitLock = (busAddr == ADDR_W'(OFS_LOCK));

  assign writeOk      = busWe && !lockedQ;
  assign wdataClamped = (busWdata == '0) ? LOAD_MIN : busWdata;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockedQ <= 1'b0;
      ctrlQ   <= 2'b00;
      loadQ   <= '1;
    end else begin
      if (busWe && hitLock)   lockedQ <= (busWdata != DATA_W'(UNLOCK_KEY));
      if (writeOk && hitLoad) loadQ   <= wdataClamped;
      if (writeOk && hitCtrl) ctrlQ   <= busWdata[1:0];
    end
  end

  assign runEn = ctrlQ[0];
  assign rstEn = ctrlQ[1];

  always_comb begin
    strobe        = '0;
    strobe.reload = writeOk && (hitLoad || hitClr);
    strobe.clrIrq = writeOk && hitClr;
  end

  assign reloadVal = (writeOk && hitLoad) ? wdataClamped : loadQ;

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_W'(OFS_LOAD):  busRdata = loadQ;
      ADDR_W'(OFS_COUNT): busRdata = cntVal;
      ADDR_W'(OFS_CTRL):  busRdata = DATA_W'(ctrlQ);
      ADDR_W'(OFS_RAW):   busRdata = DATA_W'(irqRaw);
      ADDR_W'(OFS_MASK):  busRdata = DATA_W'(irqRaw && runEn);
      ADDR_W'(OFS_LOCK):  busRdata = DATA_W'(lockedQ);
      default:            busRdata = '0;
    endcase
  end
endmodule

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  wdStrobe_t         strobe,
  input  logic [DATA_W-1:0] reloadVal,
  input  logic              runEn,
  input  logic              rstEn,
  output logic [DATA_W-1:0] cntVal,
  output logic              irqRaw,
  output logic              sysRstQ
);
  logic expire;

  assign expire = runEn && (cntVal == '0) && !strobe.reload;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntVal  <= '1;
      irqRaw  <= 1'b0;
      sysRstQ <= 1'b0;
    end else begin
      if (strobe.reload)     cntVal <= reloadVal;
      else if (expire)       cntVal <= reloadVal;
      else if (runEn)        cntVal <= cntVal - 1'b1;

      if (strobe.clrIrq)     irqRaw <= 1'b0;
      else if (expire)       irqRaw <= 1'b1;

      if (expire && irqRaw && rstEn) sysRstQ <= 1'b1;
    end
  end
endmodule

// File: rtl/twostage_wdog.sv
module twostage_wdog
  import wdog_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut,
  output logic              sysRstOut
);
  wdStrobe_t         strobe;
  logic [DATA_W-1:0] reloadVal;
  logic [DATA_W-1:0] cntVal;
  logic              irqRaw, runEn, rstEn, lockedQ;
  logic [1:0]        ctrlQ;

  wdog_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .cntVal(cntVal),
    .irqRaw(irqRaw), .reloadVal(reloadVal), .runEn(runEn),
    .rstEn(rstEn), .lockedQ(lockedQ), .ctrlQ(ctrlQ), .strobe(strobe)
  );

  wdog_count #(.DATA_W(DATA_W)) u_count (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reloadVal(reloadVal),
    .runEn(runEn), .rstEn(rstEn), .cntVal(cntVal), .irqRaw(irqRaw),
    .sysRstQ(sysRstOut)
  );

  assign irqOut = irqRaw && runEn;
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk
  import wdog_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic [DATA_W-1:0] busWdata,
  input logic              irqOut,
  input logic              sysRstOut,
  input logic [DATA_W-1:0] cntVal,
  input logic              irqRaw,
  input logic              runEn,
  input logic              lockedQ,
  input logic [1:0]        ctrlQ
);
  logic anyReload;
  assign anyReload = busWe && !lockedQ &&
                     (busAddr == ADDR_W'(OFS_LOAD) || busAddr == ADDR_W'(OFS_CLR));

  // R7
  rst_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    sysRstOut |=> sysRstOut);

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && cntVal != '0 && !anyReload) |=> (cntVal == $past(cntVal) - 1'b1));

  // R5
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn && !anyReload) |=> $stable(cntVal));

  // R6
  expire_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && cntVal == '0 && !anyReload) |=> irqRaw);

  // R3
  locked_ctrl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lockedQ && busWe && busAddr != ADDR_W'(OFS_LOCK)) |=> $stable(ctrlQ));

  // R4
  load_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && !lockedQ && busAddr == ADDR_W'(OFS_LOAD) && busWdata != '0)
      |=> (cntVal == $past(busWdata)));

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |-> !irqOut);
endmodule

bind twostage_wdog wdog_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
  .busWdata(busWdata), .irqOut(irqOut), .sysRstOut(sysRstOut),
  .cntVal(cntVal), .irqRaw(irqRaw), .runEn(runEn), .lockedQ(lockedQ),
  .ctrlQ(ctrlQ)
);

// File: tb/twostage_wdog_tb.sv
module twostage_wdog_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut, sysRstOut;
  int total = 0;
  int bad = 0;

  localparam logic [31:0] KEY = 32'h1ACC_E551;

  always #5 clk = ~clk;

  twostage_wdog u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut),
    .sysRstOut(sysRstOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    idle(2);
    rstN = 1'b1;
  endtask

  function automatic logic [31:0] expCount(input int l, input int n);
    return 32'(l - (n % (l + 1)));
  endfunction

  initial begin
    #(10 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v, c0;
    void'($urandom(32'd4242));
    doReset();

    // R1 reset state
    rd(12'h000, v); chk("R1 load", v, 32'hFFFF_FFFF);
    rd(12'h004, v); chk("R1 count", v, 32'hFFFF_FFFF);
    rd(12'h008, v); chk("R1 ctrl", v, 0);
    rd(12'h010, v); chk("R1 raw", v, 0);
    rd(12'h014, v); chk("R1 masked", v, 0);
    rd(12'hC00, v); chk("R1 lock", v, 0);
    chk("R1 pins", {30'd0, irqOut, sysRstOut}, 0);

    // R10 unmapped
    rd(12'h018, v); chk("R10 unmapped", v, 0);
    rd(12'h800, v); chk("R10 unmapped", v, 0);

    // R4 zero clamps to one
    wr(12'h000, 32'd0);
    rd(12'h000, v); chk("R4 clamp load", v, 1);
    rd(12'h004, v); chk("R4 clamp count", v, 1);

    // R6 R5 R7 random runs
    for (int it = 0; it < 24; it++) begin
      int l, n;
      logic [1:0] cm;
      l  = 2 + int'($urandom % 11);
      n  = int'($urandom % (3 * l + 3));
      cm = ($urandom % 2) ? 2'b11 : 2'b01;
      doReset();
      wr(12'h008, {30'd0, cm});
      wr(12'h000, 32'(l));
      idle(n);
      rd(12'h004, v); chk("R5 count", v, expCount(l, n));
      rd(12'h010, v); chk("R6 raw", v, (n >= l + 1) ? 1 : 0);
      chk("R7 reset pin", {31'd0, sysRstOut}, (cm[1] && n >= 2 * (l + 1)) ? 1 : 0);
    end

    // R6 exact edge: L=3 raises at 4th edge
    doReset();
    wr(12'h008, 32'd1);
    wr(12'h000, 32'd3);
    idle(3);
    rd(12'h010, v); chk("R6 not yet", v, 0);
    idle(1);
    rd(12'h010, v); chk("R6 raised", v, 1);
    rd(12'h004, v); chk("R6 reloaded", v, 3);

    // R9 masking, R5 hold
    rd(12'h014, v); chk("R9 masked on", v, 1);
    chk("R9 irq pin on", {31'd0, irqOut}, 1);
    wr(12'h008, 32'd0);
    rd(12'h010, v); chk("R9 raw kept", v, 1);
    rd(12'h014, v); chk("R9 masked off", v, 0);
    chk("R9 irq pin off", {31'd0, irqOut}, 0);
    rd(12'h004, c0);
    idle(4);
    rd(12'h004, v); chk("R5 hold", v, c0);

    // R2 R3 lock
    wr(12'hC00, 32'h0000_0001);
    rd(12'hC00, v); chk("R2 locked", v, 1);
    wr(12'h000, 32'd7);
    rd(12'h000, v); chk("R3 load ignored", v, 3);
    wr(12'h008, 32'd1);
    rd(12'h008, v); chk("R3 ctrl ignored", v, 0);
    wr(12'h00C, 32'd1);
    rd(12'h010, v); chk("R3 clear ignored", v, 1);
    rd(12'h004, v); chk("R3 count unchanged", v, c0);
    wr(12'hC00, 32'h1ACC_E550);
    rd(12'hC00, v); chk("R2 near key keeps lock", v, 1);
    wr(12'hC00, KEY);
    rd(12'hC00, v); chk("R2 unlocked", v, 0);
    wr(12'h00C, 32'd0);
    rd(12'h010, v); chk("R8 clear after unlock", v, 0);

    // R8 clear reloads
    doReset();
    wr(12'h008, 32'd1);
    wr(12'h000, 32'd5);
    idle(8);
    rd(12'h004, v); chk("R8 pre count", v, 3);
    wr(12'h00C, 32'hDEAD_BEEF);
    rd(12'h004, v); chk("R8 reload", v, 5);
    rd(12'h010, v); chk("R8 raw cleared", v, 0);
    idle(3);
    rd(12'h004, v); chk("R8 counting", v, 2);

    // R8 ping avoids reset, R7 needs pending irq
    doReset();
    wr(12'h008, 32'd3);
    wr(12'h000, 32'd4);
    idle(6);
    wr(12'h00C, 32'd1);
    idle(5);
    rd(12'h010, v); chk("R8 raw after ping", v, 1);
    chk("R7 no reset after ping", {31'd0, sysRstOut}, 0);

    // R7 sticky
    doReset();
    wr(12'h008, 32'd3);
    wr(12'h000, 32'd2);
    idle(6);
    chk("R7 reset asserted", {31'd0, sysRstOut}, 1);
    wr(12'h008, 32'd0);
    wr(12'h00C, 32'd1);
    idle(2);
    chk("R7 reset sticky", {31'd0, sysRstOut}, 1);
    doReset();
    chk("R7 reset released", {31'd0, sysRstOut}, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule